// File: doc/BRIEF.md
# Bitwise-AND Instruction Execute Unit

This block takes one already-split instruction of the AND family per cycle and returns its outcome one clock later. It decodes the prefixes, the opcode and the ModRM byte, extends the immediate, and picks the byte lanes of the two operand values it is given. It then forms the AND and the flag word, and merges the result into the full 64-bit destination register image. A pipeline stage upstream provides the register selected by ModRM.reg, or the accumulator for the short forms, on `reg_val`. It provides the r/m operand, either a register or data read from memory, on `rm_val`. Downstream logic uses the destination descriptor and the write strobe to commit the result.

The block classifies each accepted instruction as executed, faulting (LOCK on a non-memory destination) or foreign (not an AND encoding). It holds that class in a four-state machine: `ST_IDLE` when no instruction was accepted, `ST_EXEC` when a result is presented, `ST_UDF` when the undefined-opcode fault is raised, and `ST_PASS` when the encoding belongs to another unit. Every state is reached from every state in one cycle. `in_valid` low leads to `ST_IDLE`. `in_valid` high leads to `ST_EXEC`, `ST_UDF` or `ST_PASS`, chosen by the decoded class. The result registers load only on entry to `ST_EXEC`, so a fault or a foreign encoding leaves every data output untouched.

Top module: `bitand_exec`

## Requirements
- R1: Opcodes 0x20–0x25 always, and 0x80/0x81/0x83 when ModRM[5:3] is 4, execute an AND. The result bits are 1 only where both operand bits are 1, truncated to the operand size.
- R2: `cpu_mode` encoding: 0 is 16-bit, 1 is 32-bit, 2 is 64-bit, 3 behaves as 32-bit. The full size is 64 when mode is 64-bit and REX.W is set. Otherwise the operand-size prefix toggles between 16 and 32 from the mode's default (16 in 16-bit mode, 32 otherwise). REX flags have no effect outside 64-bit mode. Opcodes 0x20, 0x22, 0x24 and 0x80 are always 8-bit. `out_size` encoding: 0 is 8, 1 is 16, 2 is 32, 3 is 64.
- R3: 0x24 and 0x80 use imm[7:0]. 0x83 sign-extends imm[7:0]. 0x25 and 0x81 use imm[15:0] at 16 bits, imm[31:0] at 32 bits, and imm[31:0] sign-extended at 64 bits.
- R4: For 0x20, 0x21, 0x80, 0x81 and 0x83, the destination is r/m (`out_dst_rm`=1) with index ModRM[2:0], and `out_dst_mem`=1 when ModRM[7:6]≠3. For 0x22 and 0x23 it is the register at ModRM[5:3]. For 0x24 and 0x25 it is register 0. Register-to-register forms take the other ModRM field as source.
- R5: For an 8-bit register operand with encoding 4–7 and no REX in 64-bit mode, the high byte (bits 15:8) of register (encoding−4) is used. The destination then reports that index with `out_byte_hi`=1. With REX in 64-bit mode, the low byte of register 4–7 is used.
- R6: `out_value` for a register destination is the new full register image. An 8-bit or 16-bit write keeps the other bits of the old register. A 32-bit write clears bits 63:32. A 64-bit write replaces everything. For a memory destination, `out_value` is the result zero-extended.
- R7: `out_flags` bit positions are {OF,SF,ZF,AF,PF,CF} = bits 5..0. OF and CF are 0. SF is the result MSB at the operand size. ZF is set when the sized result is 0. PF is set when result bits 7:0 hold an even number of ones. AF copies `af_in`.
- R8: An AND encoding with LOCK whose destination is not memory raises `out_ud` the next cycle. `out_wr` stays low and all data outputs keep their values.
- R9: Any other opcode, or 0x80/0x81/0x83 with ModRM[5:3]≠4, raises `out_pass` the next cycle, even with LOCK, with `out_ud` and `out_wr` low and data outputs unchanged.
- R10: Outcomes appear exactly one cycle after `in_valid`. At most one of `out_wr`/`out_ud`/`out_pass` is high, and all are low after a cycle with `in_valid` low.
- R11: While `rst_n` is low, all strobes and data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| pfx_osz | input | 1 | Operand-size override prefix present |
| pfx_rex | input | 1 | A REX prefix present |
| pfx_rexw | input | 1 | REX.W set |
| pfx_lock | input | 1 | LOCK prefix present |
| cpu_mode | input | 2 | Current mode (R2 encoding) |
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModRM byte (ignored by short forms) |
| imm | input | 32 | Immediate field, low-aligned |
| reg_val | input | 64 | Register named by ModRM.reg, or accumulator for short forms |
| rm_val | input | 64 | r/m operand: full register or memory data |
| af_in | input | 1 | Current AF, passed through |
| out_wr | output | 1 | Result valid, commit it |
| out_ud | output | 1 | Undefined-opcode fault |
| out_pass | output | 1 | Encoding not handled by this unit |
| out_value | output | 64 | Merged destination image |
| out_dst_rm | output | 1 | Destination is the r/m operand |
| out_dst_mem | output | 1 | Destination is memory |
| out_reg_idx | output | 3 | Destination register index |
| out_byte_hi | output | 1 | Destination is bits 15:8 of that register |
| out_size | output | 2 | Operand size (R2 encoding) |
| out_flags | output | 6 | {OF,SF,ZF,AF,PF,CF} |

## Verification
Two checks can fire on the same instruction: the LOCK-legality fault and the group-code filter that marks 0x80/0x81/0x83 with a non-4 ModRM.reg as foreign. The bench provokes both at once by sending LOCK with such a group encoding in register and in memory form, and expects the foreign outcome with no fault. Byte-high selection can also hit the destination and the source of one register form in the same cycle. Directed 0x20/0x22 cases with encodings 4–7 on both fields, with and without REX, are judged field by field against a behavioural model on every clock.

// File: rtl/bitand_pkg.sv
package bitand_pkg;

    localparam int unsigned XLEN   = 64;
    localparam int unsigned IMMW   = 32;
    localparam int unsigned BYTEW  = 8;
    localparam int unsigned NLANE  = XLEN / BYTEW;
    localparam int unsigned LCNT_W = $clog2(NLANE) + 1;
    localparam int unsigned RIDX_W = 3;
    localparam int unsigned FLAG_W = 6;

    localparam int unsigned FL_CF = 0;
    localparam int unsigned FL_PF = 1;
    localparam int unsigned FL_AF = 2;
    localparam int unsigned FL_ZF = 3;
    localparam int unsigned FL_SF = 4;
    localparam int unsigned FL_OF = 5;

    localparam logic [2:0] GRP_AND = 3'd4;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_D = 2'd2,
        SZ_Q = 2'd3
    } opsz_e;

    typedef enum logic [1:0] {
        MODE_16  = 2'd0,
        MODE_32  = 2'd1,
        MODE_64  = 2'd2,
        MODE_RSV = 2'd3
    } cpumode_e;

    typedef enum logic [1:0] {
        IMM_NONE = 2'd0,
        IMM_B    = 2'd1,
        IMM_BSX  = 2'd2,
        IMM_FULL = 2'd3
    } immk_e;

    typedef enum logic [1:0] {
        CLS_EXEC    = 2'd0,
        CLS_FAULT   = 2'd1,
        CLS_FOREIGN = 2'd2
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_UDF  = 2'd2,
        ST_PASS = 2'd3
    } state_e;

    typedef struct packed {
        cls_e              cls;
        opsz_e             size;
        logic              dst_rm;
        logic              dst_mem;
        logic [RIDX_W-1:0] dst_idx;
        logic              dst_hi;
        logic              src_hi;
        immk_e             immk;
    } dec_t;

endpackage

// File: rtl/bitand_decode.sv
module bitand_decode
    import bitand_pkg::*;
(
    input  logic       pfx_osz,
    input  logic       pfx_rex,
    input  logic       pfx_rexw,
    input  logic       pfx_lock,
    input  logic [1:0] cpu_mode,
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    output dec_t       dec
);

    // An 8-bit register operand with encoding 4..7 names a high byte
    // unless a REX prefix is active.
    function automatic logic hi_sel(input logic byte_op, input logic rex_act,
                                    input logic is_reg, input logic [RIDX_W-1:0] fld);
        return byte_op & ~rex_act & is_reg & fld[RIDX_W-1];
    endfunction

    logic              long_mode;
    logic              rex_on;
    logic              wide;
    logic              mod_reg;
    logic [RIDX_W-1:0] f_reg;
    logic [RIDX_W-1:0] f_rm;
    logic              grp_and;
    opsz_e             full_sz;

    always_comb begin
        long_mode = (cpu_mode == MODE_64);
        rex_on    = long_mode & (pfx_rex | pfx_rexw);
        wide      = long_mode & pfx_rexw;
        mod_reg   = (modrm[7:6] == 2'b11);
        f_reg     = modrm[5:3];
        f_rm      = modrm[2:0];
        grp_and   = (f_reg == GRP_AND);
        if (wide)
            full_sz = SZ_Q;
        else if (cpu_mode == MODE_16)
            full_sz = pfx_osz ? SZ_D : SZ_W;
        else
            full_sz = pfx_osz ? SZ_W : SZ_D;
    end

    logic              handled;
    logic              is_byte;
    logic              dst_is_rm;
    logic              short_form;
    immk_e             immk;
    logic [RIDX_W-1:0] dfield;
    logic              d_is_reg;
    logic [RIDX_W-1:0] sfield;
    logic              s_is_reg;
    logic              d_hi;

    always_comb begin
        handled    = 1'b0;
        is_byte    = 1'b0;
        dst_is_rm  = 1'b0;
        short_form = 1'b0;
        immk       = IMM_NONE;
        unique case (opcode)
            8'h20: begin handled = 1'b1; is_byte = 1'b1; dst_is_rm = 1'b1; end
            8'h21: begin handled = 1'b1; dst_is_rm = 1'b1; end
            8'h22: begin handled = 1'b1; is_byte = 1'b1; end
            8'h23: begin handled = 1'b1; end
            8'h24: begin handled = 1'b1; is_byte = 1'b1; short_form = 1'b1; immk = IMM_B; end
            8'h25: begin handled = 1'b1; short_form = 1'b1; immk = IMM_FULL; end
            8'h80: begin handled = grp_and; is_byte = 1'b1; dst_is_rm = 1'b1; immk = IMM_B; end
            8'h81: begin handled = grp_and; dst_is_rm = 1'b1; immk = IMM_FULL; end
            8'h83: begin handled = grp_and; dst_is_rm = 1'b1; immk = IMM_BSX; end
            default: ;
        endcase

        if (short_form) begin
            dfield   = '0;
            d_is_reg = 1'b1;
        end else if (dst_is_rm) begin
            dfield   = f_rm;
            d_is_reg = mod_reg;
        end else begin
            dfield   = f_reg;
            d_is_reg = 1'b1;
        end
        sfield   = dst_is_rm ? f_reg : f_rm;
        s_is_reg = dst_is_rm ? 1'b1 : mod_reg;
        d_hi     = hi_sel(is_byte, rex_on, d_is_reg, dfield);

        dec         = '0;
        dec.size    = is_byte ? SZ_B : full_sz;
        dec.dst_rm  = dst_is_rm;
        dec.dst_mem = dst_is_rm & ~mod_reg;
        dec.dst_hi  = d_hi;
        dec.dst_idx = d_hi ? {1'b0, dfield[RIDX_W-2:0]} : dfield;
        dec.src_hi  = (immk == IMM_NONE) & hi_sel(is_byte, rex_on, s_is_reg, sfield);
        dec.immk    = immk;
        if (!handled)
            dec.cls = CLS_FOREIGN;
        else if (pfx_lock && !(dst_is_rm && !mod_reg))
            dec.cls = CLS_FAULT;
        else
            dec.cls = CLS_EXEC;
    end

endmodule

// File: rtl/bitand_operand.sv
module bitand_operand
    import bitand_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned IW = IMMW
) (
    input  dec_t           dec,
    input  logic [IW-1:0]  imm,
    input  logic [W-1:0]   reg_val,
    input  logic [W-1:0]   rm_val,
    output logic [W-1:0]   dst_old,
    output logic [W-1:0]   dst_op,
    output logic [W-1:0]   src_op
);

    logic [W-1:0] src_raw;
    logic [W-1:0] imm_ext;

    always_comb begin
        dst_old = dec.dst_rm ? rm_val : reg_val;
        dst_op  = dec.dst_hi ? (dst_old >> BYTEW) : dst_old;
        src_raw = dec.dst_rm ? reg_val : rm_val;

        unique case (dec.immk)
            IMM_B:    imm_ext = W'(imm[BYTEW-1:0]);
            IMM_BSX:  imm_ext = {{(W-BYTEW){imm[BYTEW-1]}}, imm[BYTEW-1:0]};
            IMM_FULL: imm_ext = (dec.size == SZ_W) ? W'(imm[2*BYTEW-1:0])
                                                   : {{(W-IW){imm[IW-1]}}, imm};
            default:  imm_ext = '0;
        endcase

        if (dec.immk != IMM_NONE)
            src_op = imm_ext;
        else
            src_op = dec.src_hi ? (src_raw >> BYTEW) : src_raw;
    end

endmodule

// File: rtl/bitand_result.sv
module bitand_result
    import bitand_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  opsz_e              size,
    input  logic               dst_hi,
    input  logic               dst_mem,
    input  logic               af_in,
    input  logic [W-1:0]       dst_old,
    input  logic [W-1:0]       dst_op,
    input  logic [W-1:0]       src_op,
    output logic [W-1:0]       wb_value,
    output logic [FLAG_W-1:0]  flags
);

    localparam int unsigned LANES = W / BYTEW;

    logic [LCNT_W-1:0] nlanes;
    logic [LANES-1:0]  lane_en;
    logic [W-1:0]      mask;
    logic [W-1:0]      raw;
    logic              msb;

    assign nlanes = LCNT_W'(1) << size;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g] = (LCNT_W'(g) < nlanes);
        assign mask[g*BYTEW +: BYTEW] = {BYTEW{lane_en[g]}};
    end

    assign raw = dst_op & src_op & mask;

    always_comb begin
        unique case (size)
            SZ_B:    msb = raw[BYTEW-1];
            SZ_W:    msb = raw[2*BYTEW-1];
            SZ_D:    msb = raw[4*BYTEW-1];
            default: msb = raw[W-1];
        endcase
    end

    always_comb begin
        if (dst_mem || size == SZ_D || size == SZ_Q)
            wb_value = raw;
        else if (dst_hi)
            wb_value = {dst_old[W-1:2*BYTEW], raw[BYTEW-1:0], dst_old[BYTEW-1:0]};
        else
            wb_value = (dst_old & ~mask) | raw;
    end

    always_comb begin
        flags        = '0;
        flags[FL_SF] = msb;
        flags[FL_ZF] = (raw == '0);
        flags[FL_PF] = ~^raw[BYTEW-1:0];
        flags[FL_AF] = af_in;
    end

endmodule

// File: rtl/bitand_exec.sv
module bitand_exec
    import bitand_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                pfx_osz,
    input  logic                pfx_rex,
    input  logic                pfx_rexw,
    input  logic                pfx_lock,
    input  logic [1:0]          cpu_mode,
    input  logic [7:0]          opcode,
    input  logic [7:0]          modrm,
    input  logic [IMMW-1:0]     imm,
    input  logic [XLEN-1:0]     reg_val,
    input  logic [XLEN-1:0]     rm_val,
    input  logic                af_in,
    output logic                out_wr,
    output logic                out_ud,
    output logic                out_pass,
    output logic [XLEN-1:0]     out_value,
    output logic                out_dst_rm,
    output logic                out_dst_mem,
    output logic [RIDX_W-1:0]   out_reg_idx,
    output logic                out_byte_hi,
    output logic [1:0]          out_size,
    output logic [FLAG_W-1:0]   out_flags
);

    dec_t              dec;
    logic [XLEN-1:0]   dst_old;
    logic [XLEN-1:0]   dst_op;
    logic [XLEN-1:0]   src_op;
    logic [XLEN-1:0]   wb_value;
    logic [FLAG_W-1:0] flags;
    state_e            state_q;
    state_e            state_d;

    bitand_decode i_decode (
        .pfx_osz  (pfx_osz),
        .pfx_rex  (pfx_rex),
        .pfx_rexw (pfx_rexw),
        .pfx_lock (pfx_lock),
        .cpu_mode (cpu_mode),
        .opcode   (opcode),
        .modrm    (modrm),
        .dec      (dec)
    );

    bitand_operand #(.W(XLEN), .IW(IMMW)) i_operand (
        .dec     (dec),
        .imm     (imm),
        .reg_val (reg_val),
        .rm_val  (rm_val),
        .dst_old (dst_old),
        .dst_op  (dst_op),
        .src_op  (src_op)
    );

    bitand_result #(.W(XLEN)) i_result (
        .size     (dec.size),
        .dst_hi   (dec.dst_hi),
        .dst_mem  (dec.dst_mem),
        .af_in    (af_in),
        .dst_old  (dst_old),
        .dst_op   (dst_op),
        .src_op   (src_op),
        .wb_value (wb_value),
        .flags    (flags)
    );

    // Next state: every state is left each cycle for the outcome of the
    // instruction presented now.
    always_comb begin
        if (!in_valid) begin
            state_d = ST_IDLE;
        end else begin
            unique case (dec.cls)
                CLS_EXEC:  state_d = ST_EXEC;
                CLS_FAULT: state_d = ST_UDF;
                default:   state_d = ST_PASS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Result registers load only when the machine enters ST_EXEC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_value   <= '0;
            out_dst_rm  <= 1'b0;
            out_dst_mem <= 1'b0;
            out_reg_idx <= '0;
            out_byte_hi <= 1'b0;
            out_size    <= '0;
            out_flags   <= '0;
        end else if (state_d == ST_EXEC) begin
            out_value   <= wb_value;
            out_dst_rm  <= dec.dst_rm;
            out_dst_mem <= dec.dst_mem;
            out_reg_idx <= dec.dst_idx;
            out_byte_hi <= dec.dst_hi;
            out_size    <= dec.size;
            out_flags   <= flags;
        end
    end

    always_comb begin
        out_wr   = 1'b0;
        out_ud   = 1'b0;
        out_pass = 1'b0;
        unique case (state_q)
            ST_EXEC: out_wr   = 1'b1;
            ST_UDF:  out_ud   = 1'b1;
            ST_PASS: out_pass = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bitand_exec_chk.sv
module bitand_exec_chk
    import bitand_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                pfx_lock,
    input logic [7:0]          opcode,
    input logic                out_wr,
    input logic                out_ud,
    input logic                out_pass,
    input logic [XLEN-1:0]     out_value,
    input logic                out_dst_rm,
    input logic                out_dst_mem,
    input logic [RIDX_W-1:0]   out_reg_idx,
    input logic                out_byte_hi,
    input logic [1:0]          out_size,
    input logic [FLAG_W-1:0]   out_flags
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({out_wr, out_ud, out_pass})); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !(out_wr || out_ud || out_pass)); // R10

    AST_MEM_ZF: assert property (@(posedge clk) disable iff (!rst_n) (out_wr && out_dst_mem) |-> (out_flags[FL_ZF] == (out_value == '0))); // R7

    AST_SF_DWORD: assert property (@(posedge clk) disable iff (!rst_n) (out_wr && !out_dst_mem && out_size == 2'd2) |-> (out_flags[FL_SF] == out_value[31])); // R7

    AST_UD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_ud |-> ($stable(out_value) && $stable(out_flags))); // R8

    AST_LOCK_REGDST: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && pfx_lock && opcode == 8'h22) |=> out_ud); // R8

    AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_pass |-> ($stable(out_value) && $stable(out_reg_idx))); // R9

    AST_HI_BYTE: assert property (@(posedge clk) disable iff (!rst_n) out_byte_hi |-> (out_size == 2'd0 && !out_dst_mem && out_reg_idx < 3'd4)); // R5

    AST_MEM_IS_RM: assert property (@(posedge clk) disable iff (!rst_n) out_dst_mem |-> out_dst_rm); // R4

    AST_ZX_DWORD: assert property (@(posedge clk) disable iff (!rst_n) (out_wr && out_size == 2'd2) |-> (out_value[XLEN-1:32] == '0)); // R6

endmodule

bind bitand_exec bitand_exec_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .pfx_lock    (pfx_lock),
    .opcode      (opcode),
    .out_wr      (out_wr),
    .out_ud      (out_ud),
    .out_pass    (out_pass),
    .out_value   (out_value),
    .out_dst_rm  (out_dst_rm),
    .out_dst_mem (out_dst_mem),
    .out_reg_idx (out_reg_idx),
    .out_byte_hi (out_byte_hi),
    .out_size    (out_size),
    .out_flags   (out_flags)
);

// File: tb/test_bitand_exec.sv
`timescale 1ns/1ps
module test_bitand_exec;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        pfx_osz, pfx_rex, pfx_rexw, pfx_lock;
    logic [1:0]  cpu_mode;
    logic [7:0]  opcode, modrm;
    logic [31:0] imm;
    logic [63:0] reg_val, rm_val;
    logic        af_in;
    logic        out_wr, out_ud, out_pass;
    logic [63:0] out_value;
    logic        out_dst_rm, out_dst_mem;
    logic [2:0]  out_reg_idx;
    logic        out_byte_hi;
    logic [1:0]  out_size;
    logic [5:0]  out_flags;

    always #2.5 clk = ~clk;

    bitand_exec i_bitand_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .pfx_osz(pfx_osz), .pfx_rex(pfx_rex), .pfx_rexw(pfx_rexw), .pfx_lock(pfx_lock),
        .cpu_mode(cpu_mode), .opcode(opcode), .modrm(modrm), .imm(imm),
        .reg_val(reg_val), .rm_val(rm_val), .af_in(af_in),
        .out_wr(out_wr), .out_ud(out_ud), .out_pass(out_pass), .out_value(out_value),
        .out_dst_rm(out_dst_rm), .out_dst_mem(out_dst_mem), .out_reg_idx(out_reg_idx),
        .out_byte_hi(out_byte_hi), .out_size(out_size), .out_flags(out_flags)
    );

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;
    string prev_tag = "R11";

    // reference model state, as seen one clock after an apply
    logic        e_wr = 0, e_ud = 0, e_pass = 0;
    logic [63:0] e_value = 0;
    logic        e_rm = 0, e_mem = 0, e_hi = 0;
    logic [2:0]  e_idx = 0;
    logic [1:0]  e_size = 0;
    logic [5:0]  e_flags = 0;

    task automatic compare();
        tests_run++;
        if ({out_wr, out_ud, out_pass} !== {e_wr, e_ud, e_pass} || out_value !== e_value ||
            out_dst_rm !== e_rm || out_dst_mem !== e_mem || out_reg_idx !== e_idx ||
            out_byte_hi !== e_hi || out_size !== e_size || out_flags !== e_flags) begin
            tests_failed++;
            $display("FAIL %s: act wr/ud/pass=%b%b%b val=%h rm=%b mem=%b idx=%0d hi=%b sz=%0d fl=%b | exp wr/ud/pass=%b%b%b val=%h rm=%b mem=%b idx=%0d hi=%b sz=%0d fl=%b",
                     prev_tag, out_wr, out_ud, out_pass, out_value, out_dst_rm, out_dst_mem,
                     out_reg_idx, out_byte_hi, out_size, out_flags,
                     e_wr, e_ud, e_pass, e_value, e_rm, e_mem, e_idx, e_hi, e_size, e_flags);
        end
    endtask

    task automatic model();
        bit longm, rx, handled, byteop, dstrm, mem, dreg, sreg, dhi, shi;
        int bits, cnt;
        logic [2:0]  dfield, sfield;
        logic [63:0] dold, dval, sval, sfull, mask, r;
        e_wr = 0; e_ud = 0; e_pass = 0;
        if (!in_valid) return;
        longm = (cpu_mode == 2);
        rx = longm && (pfx_rex || pfx_rexw);
        if (longm && pfx_rexw) bits = 64;
        else if (cpu_mode == 0) bits = pfx_osz ? 32 : 16;
        else bits = pfx_osz ? 16 : 32;
        handled = (opcode >= 8'h20 && opcode <= 8'h25) ||
                  ((opcode == 8'h80 || opcode == 8'h81 || opcode == 8'h83) && modrm[5:3] == 3'd4);
        if (!handled) begin e_pass = 1; return; end
        byteop = (opcode == 8'h20 || opcode == 8'h22 || opcode == 8'h24 || opcode == 8'h80);
        if (byteop) bits = 8;
        dstrm = (opcode == 8'h20 || opcode == 8'h21 || opcode >= 8'h80);
        mem = dstrm && modrm[7:6] != 2'b11;
        if (pfx_lock && !mem) begin e_ud = 1; return; end
        e_wr = 1;
        if (opcode == 8'h24 || opcode == 8'h25) begin dfield = 0; dreg = 1; end
        else if (dstrm) begin dfield = modrm[2:0]; dreg = (modrm[7:6] == 2'b11); end
        else begin dfield = modrm[5:3]; dreg = 1; end
        dold = dstrm ? rm_val : reg_val;
        dhi = (bits == 8) && !rx && dreg && dfield >= 4;
        dval = dhi ? {56'd0, dold[15:8]} : dold;
        case (opcode)
            8'h24, 8'h80: sval = {56'd0, imm[7:0]};
            8'h83:        sval = {{56{imm[7]}}, imm[7:0]};
            8'h25, 8'h81: sval = (bits == 16) ? {48'd0, imm[15:0]} : {{32{imm[31]}}, imm};
            default: begin
                sfull = dstrm ? reg_val : rm_val;
                sfield = dstrm ? modrm[5:3] : modrm[2:0];
                sreg = dstrm ? 1'b1 : (modrm[7:6] == 2'b11);
                shi = (bits == 8) && !rx && sreg && sfield >= 4;
                sval = shi ? {56'd0, sfull[15:8]} : sfull;
            end
        endcase
        mask = (bits == 64) ? '1 : ((64'd1 << bits) - 1);
        r = dval & sval & mask;
        if (mem || bits >= 32) e_value = r;
        else if (dhi) e_value = (dold & ~64'hFF00) | (r << 8);
        else e_value = (dold & ~mask) | r;
        cnt = 0;
        for (int i = 0; i < 8; i++) cnt += r[i];
        e_flags = {1'b0, r[bits-1], (r == 0), af_in, (cnt % 2 == 0), 1'b0};
        e_size = (bits == 8) ? 2'd0 : (bits == 16) ? 2'd1 : (bits == 32) ? 2'd2 : 2'd3;
        e_rm = dstrm; e_mem = mem; e_hi = dhi;
        e_idx = dhi ? dfield - 3'd4 : dfield;
    endtask

    task automatic step(input string tag, input logic v, input logic [1:0] md,
                        input logic osz, input logic rex, input logic rexw, input logic lock,
                        input logic [7:0] opc, input logic [7:0] mrm, input logic [31:0] im,
                        input logic [63:0] rv, input logic [63:0] mv, input logic af);
        @(negedge clk);
        compare();
        in_valid = v; cpu_mode = md; pfx_osz = osz; pfx_rex = rex; pfx_rexw = rexw;
        pfx_lock = lock; opcode = opc; modrm = mrm; imm = im; reg_val = rv; rm_val = mv;
        af_in = af;
        model();
        prev_tag = tag;
    endtask

    localparam logic [63:0] RV = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] MV = 64'h0F0F_F0F0_C3CC_A5F5;

    initial begin
        #(200000 * 5);
        if (!finished) begin
            tests_failed++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        rst_n = 0; in_valid = 0; pfx_osz = 0; pfx_rex = 0; pfx_rexw = 0; pfx_lock = 0;
        cpu_mode = 1; opcode = 0; modrm = 0; imm = 0; reg_val = 0; rm_val = 0; af_in = 0;
        repeat (3) @(negedge clk);
        compare();                             // R11 reset state
        rst_n = 1;
        step("R11", 0, 1, 0,0,0,0, 8'h00, 8'h00, 0, 0, 0, 0);
        step("R1",  1, 1, 0,0,0,0, 8'h24, 8'h00, 32'h0000_005A, RV, MV, 0);
        step("R3",  1, 0, 0,0,0,0, 8'h25, 8'h00, 32'hFFFF_F0F0, RV, MV, 1);
        step("R3",  1, 2, 0,1,1,0, 8'h25, 8'h00, 32'h8000_0F00, RV, MV, 0);
        step("R3",  1, 1, 0,0,0,0, 8'h83, 8'hE3, 32'h0000_00F0, RV, MV, 0);
        step("R3",  1, 2, 0,1,1,0, 8'h81, 8'hE1, 32'hF0F0_0001, RV, MV, 0);
        step("R5",  1, 1, 0,0,0,0, 8'h80, 8'hE5, 32'h0000_00FF, RV, MV, 0);
        step("R5",  1, 2, 0,1,0,0, 8'h80, 8'hE5, 32'h0000_00FF, RV, MV, 0);
        step("R5",  1, 1, 0,0,0,0, 8'h20, 8'hFC, 0, RV, MV, 0);
        step("R5",  1, 2, 0,1,0,0, 8'h22, 8'hF6, 0, RV, MV, 1);
        step("R5",  1, 2, 0,1,0,0, 8'h20, 8'hE7, 0, RV, MV, 0);
        step("R4",  1, 1, 0,0,0,0, 8'h22, 8'hD8, 0, RV, MV, 0);
        step("R4",  1, 1, 0,0,0,0, 8'h21, 8'h4E, 0, RV, MV, 0);
        step("R8",  1, 1, 0,0,0,1, 8'h21, 8'h0E, 0, RV, MV, 0);
        step("R8",  1, 1, 0,0,0,1, 8'h22, 8'h0E, 0, RV, MV, 0);
        step("R8",  1, 1, 0,0,0,1, 8'h24, 8'h00, 32'h11, RV, MV, 0);
        step("R8",  1, 2, 0,1,1,1, 8'h21, 8'hC1, 0, RV, MV, 0);
        step("R9",  1, 1, 0,0,0,1, 8'h81, 8'hC9, 32'h1234, RV, MV, 0);
        step("R9",  1, 1, 0,0,0,1, 8'h83, 8'h0E, 32'h12, RV, MV, 0);
        step("R9",  1, 1, 0,0,0,0, 8'h0F, 8'hC0, 0, RV, MV, 0);
        step("R9",  1, 1, 0,0,0,0, 8'h26, 8'hC0, 0, RV, MV, 0);
        step("R10", 0, 1, 0,0,0,0, 8'h21, 8'hC0, 0, RV, MV, 0);
        step("R6",  1, 2, 0,0,0,0, 8'h21, 8'hC8, 0, RV, MV, 0);
        step("R6",  1, 1, 1,0,0,0, 8'h23, 8'hC1, 0, RV, MV, 0);
        step("R6",  1, 2, 0,1,1,0, 8'h23, 8'hC1, 0, RV, MV, 0);
        step("R2",  1, 1, 0,1,1,0, 8'h21, 8'hC1, 0, RV, MV, 0);
        step("R2",  1, 0, 1,0,0,0, 8'h21, 8'hC1, 0, RV, MV, 0);
        step("R2",  1, 3, 0,0,0,0, 8'h21, 8'hC1, 0, RV, MV, 0);
        step("R2",  1, 2, 1,0,0,0, 8'h23, 8'hC1, 0, RV, MV, 0);
        step("R7",  1, 1, 0,0,0,0, 8'h21, 8'h01, 0, 64'hFFFF_0000, 64'h0000_FFFF, 1);
        step("R7",  1, 1, 0,0,0,0, 8'h24, 8'h00, 32'h03, 64'hFF, 0, 0);
        step("R7",  1, 2, 0,1,1,0, 8'h21, 8'hC1, 0, 64'h8000_0000_0000_0007, 64'hF000_0000_0000_0001, 0);
        step("R10", 0, 1, 0,0,0,0, 8'h00, 8'h00, 0, 0, 0, 0);
        step("R10", 0, 1, 0,0,0,0, 8'h00, 8'h00, 0, 0, 0, 0);
        for (int n = 0; n < 400; n++) begin
            logic [7:0] ops [12];
            ops = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h80, 8'h81, 8'h83, 8'h08, 8'h31, 8'h0F};
            step("R1", ($urandom % 8) != 0, 2'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), ($urandom % 4) == 0, ops[$urandom % 12], 8'($urandom),
                 $urandom, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
        end
        step("R10", 0, 1, 0,0,0,0, 8'h00, 8'h00, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule